// File: doc/BRIEF.md
# Multi-Queue Circular Buffer Manager

This block keeps 64 independent hardware FIFO queues in a single shared on-chip word memory of 2048 words of 32 bits (8 Kbytes). Each queue is a circular buffer. Software gives each queue its own region of the memory, a capacity, an entry width and two watermark levels. All of this happens through one register-mapped bus slave port. The same port carries pushes, pops, status reads, interrupt set-up and raw memory access. Pushes and pops are serialised, one word per cycle. An entry of two or four words is moved as consecutive accesses to the same queue address. The queue pointers move only once the last word of the entry has been transferred.

Each queue keeps four status flags: empty, low-water, high-water and full. The flags of the lower 32 queues are driven continuously onto a parallel flag bus for an external consumer. Each queue also carries a sticky interrupt-status bit and an enable bit. The lower half of the queues drives one interrupt line and the upper half drives the other. A lower-half queue raises its status bit on a programmable edge of a chosen flag. An upper-half queue always raises it when its high-water flag rises.

The bus address is 13 bits wide. Bits [12:11] select the region and bits [10:0] give the offset. Region 0 is queue data (offset = queue number). Region 1 is queue configuration (offset = queue number). Region 2 holds status and interrupts. Region 3 is raw memory (offset = word address).

Top module: `mqbuf_manager`

## Requirements
- R1: After reset every queue is empty and holds the default configuration: base 0, capacity 16, entry width 1, low watermark 4, high watermark 12, source = rising edge of empty. Each flag-bus nibble reads 4'b0011, both interrupt lines are low and busRvalid is low.
- R2: A configuration word has these fields: base [10:0], capacity code [12:11] (16 << code words), entry code [14:13] (1 << code words, code 3 illegal), low watermark [21:15], high watermark [28:22], flag select [30:29] (0 empty, 1 low-water, 2 high-water, 3 full) and edge [31] (1 rising, 0 falling). The word is rejected, leaving the old configuration readable in region 1, when the entry code is 3, when base plus capacity exceeds 2048, or when the capacity is not a multiple of the entry width. An accepted write empties the queue and clears its sticky error bits.
- R3: Words pop in the order they were pushed. They are stored at base + (pointer mod capacity), so the pointers wrap around inside the queue's own region.
- R4: For entries of 2 or 4 words, the word count and pointers change only when the last word of an entry is pushed or popped.
- R5: A push to a full queue is ignored and sets the sticky overflow bit. A pop from an empty queue returns 0, changes nothing else and sets the sticky underflow bit.
- R6: Reading region 2 at offset q returns the status word of queue q: count [7:0], empty [8], low-water (count <= low watermark) [9], high-water (count >= high watermark) [10], full (count == capacity) [11], overflow [12], underflow [13]. These values reflect a push or pop from the cycle after it is taken.
- R7: The flag bus carries queue q (q < 32) in bits [4q+3:4q], ordered {full, high-water, low-water, empty}.
- R8: A queue q < 32 sets interrupt-status bit q on the configured edge of its selected flag. Region 2 offset 64 reads that half of the status and clears it by writing 1s, and offset 66 holds the enable bits. irqLow is high while any enabled bit is set.
- R9: A queue q >= 32 sets interrupt-status bit q only when its high-water flag rises, whatever its configured source. Offsets 65 and 67 hold bit q-32 of the status and enable registers, and irqHigh is high while any enabled bit is set.
- R10: Region 3 reads and writes single memory words directly, and queue data is visible there.
- R11: Read data and busRvalid appear in the cycle after the read request is taken, and busRvalid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 13 | Region [12:11] and offset [10:0] |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after request |
| busRvalid | output | 1 | Read data valid |
| flagBus | output | 128 | Four flags for each of queues 0 to 31 |
| irqLow | output | 1 | Interrupt for queues 0 to 31 |
| irqHigh | output | 1 | Interrupt for queues 32 to 63 |

## Verification
Read data and busRvalid are due on the edge after the request. The bench drives each access on a falling edge and samples one full cycle later. Counts, flags and the flag bus change on the edge that takes the push or pop, so the bench checks them directly after the write task returns. Interrupt-status bits and the interrupt lines lag the flags by one more edge, so each interrupt check waits exactly one extra cycle. A clearing write acts on its own edge and is checked right after it. The negative cases are checked at the pins in the cycle where a wrong value would first appear. These are the interrupt line staying low on an unenabled or non-matching event, and a rejected configuration that must read back unchanged.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int BASE_W = 11;
  localparam int WM_W   = 7;
  localparam int CNT_W  = 8;
  localparam int PTR_W  = 7;

  typedef enum logic [1:0] {
    RG_QACC = 2'd0,
    RG_CFG  = 2'd1,
    RG_STAT = 2'd2,
    RG_RAM  = 2'd3
  } region_e;

  typedef struct packed {
    logic              pol;
    logic [1:0]        flagSel;
    logic [WM_W-1:0]   highWm;
    logic [WM_W-1:0]   lowWm;
    logic [1:0]        entrySel;
    logic [1:0]        sizeSel;
    logic [BASE_W-1:0] base;
  } qcfg_t;

  localparam qcfg_t RESET_CFG = '{pol: 1'b1, flagSel: 2'd0, highWm: 7'd12,
                                  lowWm: 7'd4, entrySel: 2'd0, sizeSel: 2'd0,
                                  base: '0};

  typedef struct packed {
    logic              push;
    logic              pop;
    logic              cfgWr;
    logic              cfgOk;
    logic              qidOk;
    logic              rdReq;
    logic              irqClr;
    logic              irqEn;
    logic              ramWr;
    region_e           region;
    logic [BASE_W-1:0] offset;
    qcfg_t             cfg;
  } strobe_t;

  function automatic logic [CNT_W-1:0] sizeWords(input logic [1:0] code);
    return CNT_W'(16) << code;
  endfunction

  function automatic logic [CNT_W-1:0] entryWords(input logic [1:0] code);
    return CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/qm_ctrl.sv
module qm_ctrl
  import qm_pkg::*;
#(
  parameter int NUM_Q      = 64,
  parameter int SRAM_WORDS = 2048,
  localparam int ADDR_W    = BASE_W + 2
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output strobe_t           stb
);
  region_e           region;
  logic [BASE_W-1:0] offset;
  logic              qidOk;
  logic              wr;
  logic              rd;
  qcfg_t             newCfg;
  logic [BASE_W:0]   endAddr;
  logic [CNT_W-1:0]  capW;
  logic [CNT_W-1:0]  entW;
  logic              legal;

  always_comb begin
    region  = region_e'(busAddr[ADDR_W-1 -: 2]);
    offset  = busAddr[BASE_W-1:0];
    qidOk   = int'(offset) < NUM_Q;
    wr      = busValid & busWrite;
    rd      = busValid & ~busWrite;
    newCfg  = qcfg_t'(busWdata);
    capW    = sizeWords(newCfg.sizeSel);
    entW    = entryWords(newCfg.entrySel);
    endAddr = {1'b0, newCfg.base} + (BASE_W+1)'(capW);
    legal   = (newCfg.entrySel != 2'd3) && (int'(endAddr) <= SRAM_WORDS)
              && ((capW & (entW - CNT_W'(1))) == '0);

    stb        = '0;
    stb.region = region;
    stb.offset = offset;
    stb.cfg    = newCfg;
    stb.qidOk  = qidOk;
    stb.rdReq  = rd;
    stb.push   = wr && region == RG_QACC && qidOk;
    stb.pop    = rd && region == RG_QACC && qidOk;
    stb.cfgWr  = wr && region == RG_CFG && qidOk;
    stb.cfgOk  = legal;
    stb.irqClr = wr && region == RG_STAT && int'(offset) == NUM_Q + int'(offset[0]);
    stb.irqEn  = wr && region == RG_STAT && int'(offset) == NUM_Q + 2 + int'(offset[0]);
    stb.ramWr  = wr && region == RG_RAM && int'(offset) < SRAM_WORDS;
  end
endmodule

// File: rtl/qm_datapath.sv
module qm_datapath
  import qm_pkg::*;
#(
  parameter int NUM_Q      = 64,
  parameter int SRAM_WORDS = 2048,
  localparam int HALF      = NUM_Q / 2,
  localparam int QW        = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [31:0]       wdata,
  output logic [31:0]       busRdata,
  output logic              busRvalid,
  output logic [4*HALF-1:0] flagBus,
  output logic              irqLow,
  output logic              irqHigh
);
  qcfg_t            cfg       [NUM_Q];
  logic [PTR_W-1:0] wrPtr     [NUM_Q];
  logic [PTR_W-1:0] rdPtr     [NUM_Q];
  logic [CNT_W-1:0] cnt       [NUM_Q];
  logic [1:0]       wrPart    [NUM_Q];
  logic [1:0]       rdPart    [NUM_Q];
  logic [3:0]       flags     [NUM_Q];
  logic [3:0]       prevFlags [NUM_Q];
  logic [NUM_Q-1:0] ovf, udf, ev, irqStat, irqEnR;
  logic [31:0]      mem [SRAM_WORDS];
  logic [31:0]      ramQ, otherQ, readMux;
  logic             fromRamQ;

  // per-queue flags and interrupt event; the parameter picks the source variant
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [CNT_W-1:0] cap;
    assign cap      = sizeWords(cfg[q].sizeSel);
    assign flags[q] = {cnt[q] == cap, cnt[q] >= CNT_W'(cfg[q].highWm),
                       cnt[q] <= CNT_W'(cfg[q].lowWm), cnt[q] == '0};
    if (q < HALF) begin : g_prog
      logic nowF, wasF;
      assign nowF  = flags[q][cfg[q].flagSel];
      assign wasF  = prevFlags[q][cfg[q].flagSel];
      assign ev[q] = cfg[q].pol ? (nowF & ~wasF) : (~nowF & wasF);
      assign flagBus[4*q +: 4] = flags[q];
    end else begin : g_fixed
      assign ev[q] = flags[q][2] & ~prevFlags[q][2];
    end
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN) cnt[q] <= cap);
  end

  // selected queue
  logic [QW-1:0]     qid;
  qcfg_t             selCfg;
  logic [CNT_W-1:0]  selCnt, selCap, selEnt;
  logic [PTR_W-1:0]  selMask;
  logic              selFull, selEmpty, lastWr, lastRd;
  logic [BASE_W-1:0] pushAddr, popAddr;
  logic              ramWe, ramRe;
  logic [BASE_W-1:0] ramWaddr, ramRaddr;
  logic [NUM_Q-1:0]  wordMask, halfMask;

  always_comb begin
    qid      = stb.offset[QW-1:0];
    selCfg   = cfg[qid];
    selCnt   = cnt[qid];
    selCap   = sizeWords(selCfg.sizeSel);
    selEnt   = entryWords(selCfg.entrySel);
    selMask  = PTR_W'(selCap - CNT_W'(1));
    selFull  = flags[qid][3];
    selEmpty = flags[qid][0];
    lastWr   = CNT_W'(wrPart[qid]) == selEnt - CNT_W'(1);
    lastRd   = CNT_W'(rdPart[qid]) == selEnt - CNT_W'(1);
    pushAddr = selCfg.base + BASE_W'((wrPtr[qid] + PTR_W'(wrPart[qid])) & selMask);
    popAddr  = selCfg.base + BASE_W'((rdPtr[qid] + PTR_W'(rdPart[qid])) & selMask);
    ramWe    = stb.ramWr | (stb.push & ~selFull);
    ramWaddr = stb.ramWr ? stb.offset : pushAddr;
    ramRe    = (stb.rdReq && stb.region == RG_RAM) | (stb.pop & ~selEmpty);
    ramRaddr = (stb.region == RG_RAM) ? stb.offset : popAddr;

    wordMask = '0;
    halfMask = '0;
    if (stb.offset[0]) begin
      wordMask[NUM_Q-1:HALF] = wdata[HALF-1:0];
      halfMask[NUM_Q-1:HALF] = '1;
    end else begin
      wordMask[HALF-1:0] = wdata[HALF-1:0];
      halfMask[HALF-1:0] = '1;
    end

    readMux = '0;
    unique case (stb.region)
      RG_CFG:  readMux = stb.qidOk ? 32'(selCfg) : '0;
      RG_STAT: begin
        if (stb.qidOk) readMux = 32'({udf[qid], ovf[qid], flags[qid], selCnt});
        else if (int'(stb.offset) == NUM_Q)     readMux = 32'(irqStat[HALF-1:0]);
        else if (int'(stb.offset) == NUM_Q + 1) readMux = 32'(irqStat[NUM_Q-1:HALF]);
        else if (int'(stb.offset) == NUM_Q + 2) readMux = 32'(irqEnR[HALF-1:0]);
        else if (int'(stb.offset) == NUM_Q + 3) readMux = 32'(irqEnR[NUM_Q-1:HALF]);
      end
      default: readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ramWe) mem[ramWaddr] <= wdata;
    if (ramRe) ramQ <= mem[ramRaddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_Q; i++) begin
        cfg[i]       <= RESET_CFG;
        wrPtr[i]     <= '0;
        rdPtr[i]     <= '0;
        cnt[i]       <= '0;
        wrPart[i]    <= '0;
        rdPart[i]    <= '0;
        prevFlags[i] <= 4'b0011;
      end
      ovf       <= '0;
      udf       <= '0;
      irqStat   <= '0;
      irqEnR    <= '0;
      busRvalid <= 1'b0;
      fromRamQ  <= 1'b0;
      otherQ    <= '0;
    end else begin
      for (int i = 0; i < NUM_Q; i++) prevFlags[i] <= flags[i];
      irqStat   <= (irqStat & ~(stb.irqClr ? wordMask : '0)) | ev;
      if (stb.irqEn) irqEnR <= (irqEnR & ~halfMask) | wordMask;
      busRvalid <= stb.rdReq;
      fromRamQ  <= ramRe;
      otherQ    <= readMux;
      if (stb.cfgWr && stb.cfgOk) begin
        cfg[qid]    <= stb.cfg;
        wrPtr[qid]  <= '0;
        rdPtr[qid]  <= '0;
        cnt[qid]    <= '0;
        wrPart[qid] <= '0;
        rdPart[qid] <= '0;
        ovf[qid]    <= 1'b0;
        udf[qid]    <= 1'b0;
      end else if (stb.push) begin
        if (selFull) ovf[qid] <= 1'b1;
        else if (lastWr) begin
          wrPart[qid] <= '0;
          wrPtr[qid]  <= (wrPtr[qid] + PTR_W'(selEnt)) & selMask;
          cnt[qid]    <= selCnt + selEnt;
        end else wrPart[qid] <= wrPart[qid] + 2'd1;
      end else if (stb.pop) begin
        if (selEmpty) udf[qid] <= 1'b1;
        else if (lastRd) begin
          rdPart[qid] <= '0;
          rdPtr[qid]  <= (rdPtr[qid] + PTR_W'(selEnt)) & selMask;
          cnt[qid]    <= selCnt - selEnt;
        end else rdPart[qid] <= rdPart[qid] + 2'd1;
      end
    end
  end

  assign busRdata = fromRamQ ? ramQ : otherQ;
  assign irqLow   = |(irqStat[HALF-1:0] & irqEnR[HALF-1:0]);
  assign irqHigh  = |(irqStat[NUM_Q-1:HALF] & irqEnR[NUM_Q-1:HALF]);

  a_r5_full_push_ignored: assert property (@(posedge clk) disable iff (!rstN)
    stb.push && selFull |=> cnt[$past(qid)] == $past(selCnt) && ovf[$past(qid)]);
  a_r5_empty_pop_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop && selEmpty |=> busRdata == '0 && udf[$past(qid)]);
  a_r2_reject_keeps_cfg: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgWr && !stb.cfgOk |=> cfg[$past(qid)] == $past(selCfg));
  a_r11_rvalid_follows: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdReq |=> busRvalid);
  a_r11_rvalid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdReq |=> !busRvalid);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irqLow |-> (irqEnR[HALF-1:0] != '0));
endmodule

// File: rtl/mqbuf_manager.sv
module mqbuf_manager
  import qm_pkg::*;
#(
  parameter int NUM_Q      = 64,
  parameter int SRAM_WORDS = 2048,
  localparam int HALF      = NUM_Q / 2,
  localparam int ADDR_W    = BASE_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busRvalid,
  output logic [4*HALF-1:0] flagBus,
  output logic              irqLow,
  output logic              irqHigh
);
  strobe_t stb;

  qm_ctrl #(.NUM_Q(NUM_Q), .SRAM_WORDS(SRAM_WORDS)) i_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .stb(stb)
  );

  qm_datapath #(.NUM_Q(NUM_Q), .SRAM_WORDS(SRAM_WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid), .flagBus(flagBus),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );
endmodule

// File: tb/test_mqbuf_manager.sv
`timescale 1ns/1ps
module test_mqbuf_manager;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [12:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [127:0] flagBus;
  logic        irqLow, irqHigh;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mqbuf_manager i_mqbuf_manager (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .flagBus(flagBus), .irqLow(irqLow), .irqHigh(irqHigh)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [12:0] addr;
    logic [31:0] data;
  } vec_t;

  // queue 1: base 100, capacity 16, entry 1, low 2, high 10, rising empty = 32'h82810064
  localparam vec_t TABLE [14] = '{
    '{1'b1, 4'd2,  13'h0801, 32'h82810064},
    '{1'b0, 4'd2,  13'h0801, 32'h82810064},
    '{1'b1, 4'd3,  13'h0001, 32'h000000A1},
    '{1'b1, 4'd3,  13'h0001, 32'h000000A2},
    '{1'b1, 4'd3,  13'h0001, 32'h000000A3},
    '{1'b0, 4'd6,  13'h1001, 32'h00000003},
    '{1'b0, 4'd3,  13'h0001, 32'h000000A1},
    '{1'b0, 4'd3,  13'h0001, 32'h000000A2},
    '{1'b0, 4'd3,  13'h0001, 32'h000000A3},
    '{1'b0, 4'd5,  13'h0001, 32'h00000000},
    '{1'b0, 4'd6,  13'h1001, 32'h00002300},
    '{1'b0, 4'd10, 13'h1865, 32'h000000A2},
    '{1'b1, 4'd10, 13'h1866, 32'h00000055},
    '{1'b0, 4'd10, 13'h1866, 32'h00000055}
  };

  function automatic logic [12:0] adr(input logic [1:0] region, input int off);
    return {region, 11'(off)};
  endfunction

  function automatic logic [31:0] cfgWord(input int base, input int sz, input int ent,
                                          input int lo, input int hi, input int pol, input int sel);
    return {1'(pol), 2'(sel), 7'(hi), 7'(lo), 2'(ent), 2'(sz), 11'(base)};
  endfunction

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd5:  return "R5";
      4'd6:  return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [12:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata; v = busRvalid;
    busValid = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    busRd(a, d, v);
    check(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 flagBus", flagBus[31:0], {8{4'h3}});
    check("R1 flagBus top", flagBus[127:96], {8{4'h3}});
    check("R1 irq", {30'b0, irqLow, irqHigh}, 32'h0);
    check("R1 rvalid", {31'b0, busRvalid}, 32'h0);
    busRd(adr(2, 0), d, v);
    check("R1 status q0", d, 32'h00000300);
    check("R11 rvalid after read", {31'b0, v}, 32'h1);

    // table walk: basic push/pop, status, underflow, raw memory
    foreach (TABLE[i]) begin
      if (TABLE[i].wr) busWr(TABLE[i].addr, TABLE[i].data);
      else rdCheck(reqName(TABLE[i].req), TABLE[i].addr, TABLE[i].data);
    end

    // R2 rejections and boundary acceptance on queue 1
    busWr(adr(1, 1), cfgWord(100, 0, 3, 2, 10, 1, 0));
    rdCheck("R2 entry code 3 rejected", adr(1, 1), 32'h82810064);
    busWr(adr(1, 1), cfgWord(2040, 0, 0, 2, 10, 1, 0));
    rdCheck("R2 past end rejected", adr(1, 1), 32'h82810064);
    busWr(adr(1, 1), cfgWord(2032, 0, 0, 2, 10, 1, 0));
    rdCheck("R2 end boundary accepted", adr(1, 1), cfgWord(2032, 0, 0, 2, 10, 1, 0));
    rdCheck("R2 accept clears queue", adr(2, 1), 32'h00000300);

    // R4 two-word entries on queue 2
    busWr(adr(1, 2), cfgWord(200, 0, 1, 0, 14, 1, 0));
    busWr(adr(0, 2), 32'hB1);
    rdCheck("R4 half entry count", adr(2, 2), 32'h00000300);
    busWr(adr(0, 2), 32'hB2);
    rdCheck("R4 full entry count", adr(2, 2), 32'h00000002);
    rdCheck("R4 pop word0", adr(0, 2), 32'hB1);
    rdCheck("R4 count held mid entry", adr(2, 2), 32'h00000002);
    rdCheck("R4 pop word1", adr(0, 2), 32'hB2);
    rdCheck("R4 entry popped", adr(2, 2), 32'h00000300);

    // R3 wrap-around on queue 3
    busWr(adr(1, 3), cfgWord(300, 0, 0, 0, 16, 1, 0));
    for (int k = 0; k < 10; k++) busWr(adr(0, 3), 32'h300 + k);
    for (int k = 0; k < 10; k++) rdCheck("R3 order first pass", adr(0, 3), 32'h300 + k);
    for (int k = 0; k < 10; k++) busWr(adr(0, 3), 32'h400 + k);
    rdCheck("R3 wrapped storage", adr(3, 300), 32'h406);
    for (int k = 0; k < 10; k++) rdCheck("R3 order after wrap", adr(0, 3), 32'h400 + k);

    // R5 overflow, R7 flag bus nibble
    for (int k = 0; k < 16; k++) busWr(adr(0, 3), 32'h500 + k);
    rdCheck("R6 full status", adr(2, 3), 32'h00000C10);
    check("R7 nibble q3 full", 32'(flagBus[15:12]), 32'hC);
    check("R7 nibble q2 empty", 32'(flagBus[11:8]), 32'h3);
    busWr(adr(0, 3), 32'h5FF);
    rdCheck("R5 overflow status", adr(2, 3), 32'h00001C10);
    rdCheck("R5 data kept", adr(0, 3), 32'h500);

    // R8 lower-half interrupt, rising high-water on queue 4
    busWr(adr(1, 4), cfgWord(400, 0, 0, 1, 3, 1, 2));
    busWr(adr(2, 64), 32'hFFFFFFFF);
    busWr(adr(2, 66), 32'h10);
    busWr(adr(0, 4), 32'h41);
    busWr(adr(0, 4), 32'h42);
    @(negedge clk);
    check("R8 no irq below mark", {31'b0, irqLow}, 32'h0);
    busWr(adr(0, 4), 32'h43);
    @(negedge clk);
    check("R8 irq on rise", {31'b0, irqLow}, 32'h1);
    rdCheck("R8 status low", adr(2, 64), 32'h10);
    busWr(adr(2, 64), 32'h10);
    check("R8 irq cleared", {31'b0, irqLow}, 32'h0);

    // R8 falling empty on queue 5, not enabled
    busWr(adr(1, 5), cfgWord(500, 0, 0, 0, 8, 0, 0));
    busWr(adr(0, 5), 32'h51);
    @(negedge clk);
    check("R8 disabled stays low", {31'b0, irqLow}, 32'h0);
    rdCheck("R8 falling edge status", adr(2, 64), 32'h20);

    // R9 upper-half fixed source on queue 40
    busWr(adr(1, 40), cfgWord(600, 0, 0, 0, 2, 0, 0));
    busWr(adr(2, 67), 32'h100);
    busWr(adr(0, 40), 32'h61);
    @(negedge clk);
    check("R9 empty fall ignored", {31'b0, irqHigh}, 32'h0);
    busWr(adr(0, 40), 32'h62);
    @(negedge clk);
    check("R9 irq on high-water", {31'b0, irqHigh}, 32'h1);
    rdCheck("R9 status high", adr(2, 65), 32'h100);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule